// File: doc/BRIEF.md
# Signed-Magnitude Restoring Divider

This block divides a double-length signed-magnitude dividend by a single-length signed-magnitude divisor over several clock cycles. The dividend arrives as one sign bit and two magnitude halves: a high half that seeds the partial-remainder register and a low half that seeds the quotient register. The divisor arrives as one sign bit and one magnitude. Each word is `WORD_W` bits wide, and one of those bits is the sign, so every magnitude field has `WORD_W-1` bits.

A one-cycle `start` pulse captures all operands at once. On the next cycle the block compares the high dividend half with the divisor magnitude. When the high half is not smaller, the quotient could not fit. The block then sets the overflow flag and finishes at once, without iterating. A zero divisor always takes this path. Otherwise it runs one restoring step per cycle for `WORD_W-1` cycles. Each step shifts the partial remainder and quotient left as one unit and tries a subtraction, done as an addition of the divisor's two's complement. It keeps the difference and sets the new quotient bit when the end carry shows the trial did not go negative. A one-cycle `done` pulse marks the cycle in which quotient, remainder and flag are valid.

Top module: `smDivider`

## Requirements
- R1: When `done` is high and `overflow` is low, `quotSign` equals `dividendSign` XOR `divisorSign` (1 means negative).
- R2: When `done` is high and `overflow` is low, `remSign` equals `dividendSign`.
- R3: If `dividendHi >= divisorMag` (as unsigned magnitudes), `overflow` is 1 while `done` is high, no division step is run, and `done` rises on the first clock edge after the edge that accepted `start`.
- R4: A divisor magnitude of zero always produces `overflow` = 1 with `done`, whatever the dividend.
- R5: Without overflow, `quotMag` and `remMag` satisfy `{dividendHi,dividendLo} = quotMag*divisorMag + remMag` with `remMag < divisorMag`.
- R6: Without overflow, `done` rises on the edge `WORD_W` clock edges after the edge that accepted `start` (one compare cycle plus `WORD_W-1` steps). It stays high for exactly one cycle.
- R7: After reset, `done` and `overflow` are 0.
- R8: A `start` that arrives while a division is in progress is ignored. The running division finishes with the results of the operands captured first, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to capture operands and begin |
| dividendSign | input | 1 | Dividend sign, 1 = negative |
| dividendHi | input | WORD_W-1 | High magnitude half of the dividend |
| dividendLo | input | WORD_W-1 | Low magnitude half of the dividend |
| divisorSign | input | 1 | Divisor sign, 1 = negative |
| divisorMag | input | WORD_W-1 | Divisor magnitude |
| done | output | 1 | One-cycle pulse, results valid |
| overflow | output | 1 | Divide overflow (includes divide by zero) |
| quotSign | output | 1 | Quotient sign |
| quotMag | output | WORD_W-1 | Quotient magnitude |
| remSign | output | 1 | Remainder sign |
| remMag | output | WORD_W-1 | Remainder magnitude |

## Verification
The bench aims at the boundary of the overflow test. A high half equal to the divisor must overflow, and one just below it, such as a maximal quotient of all ones, must not. A design that compared with strict greater-than would produce a wrapped quotient, and one that missed the lost shift-out bit would go wrong on large remainders. Divide by zero with a tiny dividend checks that the flag does not depend on the dividend. Mixed signs and a zero quotient check the sign rules. A start pulse with different operands is injected in the middle of a run. A design that accepted it would restart, show the wrong latency, or report the second operand set.

// File: rtl/divPkg.sv
package divPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } divState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands
    logic check;  // overflow compare cycle
    logic step;   // one shift-subtract-restore iteration
  } strobes_t;

endpackage

// File: rtl/smDivSubtractor.sv
module smDivSubtractor #(
  parameter int W = 7
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         carryOut
);
  // minuend + two's complement of subtrahend; carry 1 means minuend >= subtrahend
  logic [W:0] sum;
  always_comb begin
    sum      = {1'b0, minuend} + {1'b0, ~subtrahend} + (W+1)'(1);
    diff     = sum[W-1:0];
    carryOut = sum[W];
  end
endmodule

// File: rtl/smDivDatapath.sv
module smDivDatapath #(
  parameter int MAG_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  divPkg::strobes_t    strb,
  input  logic                dividendSign,
  input  logic [MAG_W-1:0]    dividendHi,
  input  logic [MAG_W-1:0]    dividendLo,
  input  logic                divisorSign,
  input  logic [MAG_W-1:0]    divisorMag,
  output logic                aGeB,
  output logic                ovfFlag,
  output logic                quotSign,
  output logic [MAG_W-1:0]    quotMag,
  output logic                remSign,
  output logic [MAG_W-1:0]    remMag
);

  logic             signDvd, signDvs;
  logic [MAG_W-1:0] aReg, qReg, bReg;

  // Overflow compare on the unshifted high half
  logic [MAG_W-1:0] cmpDiff;
  smDivSubtractor #(.W(MAG_W)) uCmp (
    .minuend(aReg), .subtrahend(bReg), .diff(cmpDiff), .carryOut(aGeB)
  );

  // One iteration: shift E,A,Q left (E receives old A msb, old E lost)
  logic             eShift;
  logic [MAG_W-1:0] aShift, qShift, stepDiff, aNext;
  logic             stepCarry, takeBit;

  always_comb begin
    {eShift, aShift, qShift} = {aReg, qReg, 1'b0};
  end

  smDivSubtractor #(.W(MAG_W)) uStep (
    .minuend(aShift), .subtrahend(bReg), .diff(stepDiff), .carryOut(stepCarry)
  );

  always_comb begin
    // shifted-out bit set means the true partial remainder exceeds B
    takeBit = eShift | stepCarry;
    aNext   = takeBit ? stepDiff : aShift;   // restore when the trial went negative
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signDvd <= 1'b0;
      signDvs <= 1'b0;
      aReg    <= '0;
      qReg    <= '0;
      bReg    <= '0;
      ovfFlag <= 1'b0;
    end else if (strb.load) begin
      signDvd <= dividendSign;
      signDvs <= divisorSign;
      aReg    <= dividendHi;
      qReg    <= dividendLo;
      bReg    <= divisorMag;
      ovfFlag <= 1'b0;
    end else if (strb.check) begin
      ovfFlag <= aGeB;
    end else if (strb.step) begin
      aReg <= aNext;
      qReg <= {qShift[MAG_W-1:1], takeBit};
    end
  end

  always_comb begin
    quotSign = signDvd ^ signDvs;
    quotMag  = qReg;
    remSign  = signDvd;
    remMag   = aReg;
  end

  // R5: each restoring step leaves the partial remainder below the divisor
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> (aReg < bReg));

  // R4: a zero divisor at the compare cycle always raises the flag
  assert_zero_divisor_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.check && bReg == '0) |=> ovfFlag);

endmodule

// File: rtl/smDivControl.sv
module smDivControl #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             aGeB,
  input  logic             ovfFlag,
  output divPkg::strobes_t strb,
  output logic             done
);
  import divPkg::*;

  localparam int CNT_W = $clog2(MAG_W + 1);

  divState_t        state, nextState;
  logic [CNT_W-1:0] seqCnt;

  always_comb begin
    strb       = '0;
    strb.load  = (state == ST_IDLE) && start;
    strb.check = (state == ST_CHECK);
    strb.step  = (state == ST_RUN);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (start) nextState = ST_CHECK;
      ST_CHECK: nextState = aGeB ? ST_FIN : ST_RUN;
      ST_RUN:   if (seqCnt == CNT_W'(1)) nextState = ST_FIN;
      ST_FIN:   nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      seqCnt <= '0;
    end else begin
      state <= nextState;
      if (strb.check)     seqCnt <= CNT_W'(MAG_W);
      else if (strb.step) seqCnt <= seqCnt - CNT_W'(1);
    end
  end

  always_comb done = (state == ST_FIN);

  // R3: an overflowed division never enters the iteration phase
  assert_no_step_on_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !ovfFlag);

  // R6: done is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: the sequence counter never runs past zero while iterating
  assert_counter_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (seqCnt != '0));

  // R8: a start during a running division does not restart it
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start) |=> (state != ST_CHECK));

endmodule

// File: rtl/smDivider.sv
module smDivider #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dividendSign,
  input  logic [WORD_W-2:0] dividendHi,
  input  logic [WORD_W-2:0] dividendLo,
  input  logic              divisorSign,
  input  logic [WORD_W-2:0] divisorMag,
  output logic              done,
  output logic              overflow,
  output logic              quotSign,
  output logic [WORD_W-2:0] quotMag,
  output logic              remSign,
  output logic [WORD_W-2:0] remMag
);
  localparam int MAG_W = WORD_W - 1;

  divPkg::strobes_t strb;
  logic             aGeB;

  smDivControl #(.MAG_W(MAG_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .aGeB(aGeB),
    .ovfFlag(overflow), .strb(strb), .done(done)
  );

  smDivDatapath #(.MAG_W(MAG_W)) uPath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .dividendSign(dividendSign), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisorSign(divisorSign), .divisorMag(divisorMag),
    .aGeB(aGeB), .ovfFlag(overflow),
    .quotSign(quotSign), .quotMag(quotMag), .remSign(remSign), .remMag(remMag)
  );

endmodule

// File: tb/smDivider_test.sv
`timescale 1ns/1ps
module smDivider_test;
  localparam int WORD_W = 8;
  localparam int MAG_W  = WORD_W - 1;
  localparam int NVEC   = 9;

  // vector layout: dvdSign(1) hi(7) lo(7) dvsSign(1) dvsMag(7)
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 7'd3,   7'd10,  1'b0, 7'd5},
    {1'b1, 7'd0,   7'd100, 1'b0, 7'd7},
    {1'b0, 7'd20,  7'd0,   1'b1, 7'd100},
    {1'b1, 7'd126, 7'd127, 1'b1, 7'd127},
    {1'b0, 7'd0,   7'd0,   1'b0, 7'd1},
    {1'b0, 7'd0,   7'd5,   1'b0, 7'd9},
    {1'b0, 7'd5,   7'd0,   1'b0, 7'd5},
    {1'b1, 7'd100, 7'd3,   1'b0, 7'd20},
    {1'b0, 7'd0,   7'd1,   1'b1, 7'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic dividendSign = 1'b0, divisorSign = 1'b0;
  logic [MAG_W-1:0] dividendHi = '0, dividendLo = '0, divisorMag = '0;
  logic done, overflow, quotSign, remSign;
  logic [MAG_W-1:0] quotMag, remMag;

  int errors = 0, checks = 0;
  int gotEdges;
  logic gotOvf, gotQs, gotRs;
  logic [MAG_W-1:0] gotQ, gotR;

  always #2 clk = ~clk;

  smDivider #(.WORD_W(WORD_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividendSign(dividendSign), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisorSign(divisorSign), .divisorMag(divisorMag),
    .done(done), .overflow(overflow), .quotSign(quotSign), .quotMag(quotMag),
    .remSign(remSign), .remMag(remMag)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // waits for done; optional mid-run start with other operands (R8)
  task automatic runOp(input logic ds, input logic [MAG_W-1:0] hi, input logic [MAG_W-1:0] lo,
                       input logic vs, input logic [MAG_W-1:0] b, input bit disturb);
    @(negedge clk);
    dividendSign = ds; dividendHi = hi; dividendLo = lo;
    divisorSign = vs; divisorMag = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    gotEdges = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      gotEdges++;
      @(negedge clk);
      if (disturb && gotEdges == 3) begin
        dividendSign = ~ds; dividendHi = '0; dividendLo = 7'd1; divisorSign = ~vs;
        divisorMag = 7'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
    gotOvf = overflow; gotQs = quotSign; gotRs = remSign; gotQ = quotMag; gotR = remMag;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 actual=no done expected=done");
    end
    @(negedge clk);
    check("R6 done single cycle", int'(done), 0);
  endtask

  task automatic runAndCheck(input logic [22:0] v, input bit disturb);
    logic ds, vs;
    logic [MAG_W-1:0] hi, lo, b;
    int dvd, expQ, expR;
    ds = v[22]; hi = v[21:15]; lo = v[14:8]; vs = v[7]; b = v[6:0];
    runOp(ds, hi, lo, vs, b, disturb);
    if (hi >= b) begin
      check(b == 0 ? "R4 zero divisor overflow" : "R3 overflow flag", int'(gotOvf), 1);
      check("R3 overflow latency", gotEdges, 1);
    end else begin
      dvd  = int'(hi) * (1 << MAG_W) + int'(lo);
      expQ = dvd / int'(b);
      expR = dvd % int'(b);
      check("R3 no overflow", int'(gotOvf), 0);
      check("R5 quotient", int'(gotQ), expQ);
      check("R5 remainder", int'(gotR), expR);
      check("R1 quotient sign", int'(gotQs), int'(ds ^ vs));
      check("R2 remainder sign", int'(gotRs), int'(ds));
      check(disturb ? "R8 latency with busy start" : "R6 latency", gotEdges, MAG_W + 1);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset done", int'(done), 0);
    check("R7 reset overflow", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset done", int'(done), 0);

    for (int i = 0; i < NVEC; i++) runAndCheck(VEC[i], 1'b0);

    // R8: busy start with different operands, results must come from first set
    runAndCheck({1'b1, 7'd3, 7'd10, 1'b0, 7'd5}, 1'b1);
    // R8: no extra done after the disturbed run
    for (int i = 0; i < MAG_W + 4; i++) begin
      @(negedge clk);
      check("R8 no extra done", int'(done), 0);
    end

    // R3 boundary: high half one below divisor (max quotient) vs equal
    runAndCheck({1'b0, 7'd9, 7'd127, 1'b1, 7'd10}, 1'b0);
    runAndCheck({1'b0, 7'd127, 7'd0, 1'b0, 7'd127}, 1'b0);
    // R4: zero divisor, zero dividend
    runAndCheck({1'b1, 7'd0, 7'd0, 1'b0, 7'd0}, 1'b0);
    // overflowed run followed by a normal one: flag must clear
    runAndCheck({1'b0, 7'd1, 7'd1, 1'b0, 7'd2}, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule